// File: doc/BRIEF.md
# Binarized Layer Accelerator (XNOR and Popcount)

This block evaluates one neuron group of a binarized neural network layer. Software programs a weight-word count and a threshold through a 32-bit APB slave, then starts a pass. The engine accepts one TP-bit activation word on its input stream and holds it in a buffer of 32-bit words. It then accepts a run of TP-bit weight words. Each weight word is XNORed with the held activations, and the matching bits are counted by an adder tree. The count goes into one of TP 16-bit saturating accumulators, chosen in round-robin order.

When the programmed number of weight words has been consumed, every accumulator is compared with the threshold. The resulting TP-bit vector is offered on the output stream and held there until the sink accepts it. All three streams use valid/ready handshakes. Fetching the data from memory and generating addresses are left to the surrounding system.

Top module: `bnn_xnor_accel`

## Requirements
- R1: Register map (byte offsets; a register is hit only when paddr bits outside [3:2] are zero, and accesses anywhere else read 0 with no effect): 0x0 command (a write with bit 0 set is a start request, reads return 0); 0x4 word count K (CNT_W bits, read back zero-extended); 0x8 threshold (ACC_W bits, read back zero-extended); 0xC status (bit 0 busy, bit 1 done). pready is always 1.
- R2: A start request while idle zeroes all accumulators, clears done and sets busy. From the next cycle inReady is 1.
- R3: A start request while a pass is in progress has no effect. The pass continues and produces its normal result.
- R4: Exactly one input word is accepted per pass. inReady drops in the cycle after the input handshake.
- R5: The j-th accepted weight word (j counted from 0 within a pass) adds the number of positions where the weight bit equals the held input bit to accumulator j mod TP.
- R6: An accumulator saturates at 2^ACC_W-1 (0xFFFF by default) instead of wrapping.
- R7: After K weight words, output bit i is 1 exactly when accumulator i is greater than or equal to the threshold. With K=0 the engine goes straight from the input handshake to the compare, and all accumulators are 0.
- R8: outData stays stable while outValid is 1 and outReady is 0. After the output handshake, outValid is 0, busy is 0 and done is 1.
- R9: wReady is 1 only while weights are being consumed. At most one of inReady, wReady and outValid is 1 at a time.
- R10: After reset, inReady, wReady and outValid are 0, and K, threshold and status all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, constant 1 |
| inValid | input | 1 | Activation word valid |
| inReady | output | 1 | Activation word accepted |
| inData | input | TP | Activation word |
| wValid | input | 1 | Weight word valid |
| wReady | output | 1 | Weight word accepted |
| wData | input | TP | Weight word |
| outValid | output | 1 | Thresholded result valid |
| outReady | input | 1 | Sink ready for result |
| outData | output | TP | Thresholded bit vector |

## Verification
The hardest case to reach from the ports is accumulator saturation. With TP=32, one accumulator sees only every 32nd word and gains at most 32 per word, so it takes 65536 weight words that match the input in every bit to reach the ceiling. The bench drives that pass with weights equal to the activation word and a threshold of 0xFFFF, so every output bit is 1 only if no accumulator wrapped. The ignored start is reached by pausing the weight stream halfway through a pass and issuing a start over APB. A restart would leave the weight stream stalled and the remaining words unconsumed. Thresholds are swept over every reachable count for a fixed pattern.

// File: rtl/bnn_pkg.sv
package bnn_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_ACC,
    ST_THRESH,
    ST_EMIT
  } bnnState_t;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic clearAcc;
    logic loadIn;
    logic accEn;
    logic latchOut;
  } dpCtrl_t;

  localparam logic [1:0] REG_CMD    = 2'd0;
  localparam logic [1:0] REG_LEN    = 2'd1;
  localparam logic [1:0] REG_THR    = 2'd2;
  localparam logic [1:0] REG_STATUS = 2'd3;

endpackage

// File: rtl/bnn_ctrl.sv
module bnn_ctrl
  import bnn_pkg::*;
#(
  parameter int ACC_W  = 16,
  parameter int CNT_W  = 20,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  input  logic              inValid,
  output logic              inReady,
  input  logic              wValid,
  output logic              wReady,
  output logic              outValid,
  input  logic              outReady,
  output logic [ACC_W-1:0]  thr,
  output dpCtrl_t           dpCtrl
);

  bnnState_t state, stateNext;
  logic [CNT_W-1:0] kReg;
  logic [CNT_W-1:0] wordCnt;
  logic [ACC_W-1:0] thrReg;
  logic             done;
  logic             busy;
  logic             regHit;
  logic [1:0]       regSel;
  logic             apbWr;
  logic             startReq;
  logic             lastWord;
  logic             unusedWdata;

  assign unusedWdata = ^pwdata[31:CNT_W];

  assign regSel   = paddr[3:2];
  assign regHit   = (paddr[ADDR_W-1:4] == '0) && (paddr[1:0] == 2'b00);
  assign apbWr    = psel && penable && pwrite && regHit;
  assign startReq = apbWr && (regSel == REG_CMD) && pwdata[0];
  assign pready   = 1'b1;
  assign busy     = (state != ST_IDLE);
  assign thr      = thrReg;

  assign inReady  = (state == ST_LOAD);
  assign wReady   = (state == ST_ACC);
  assign outValid = (state == ST_EMIT);
  assign lastWord = (wordCnt == kReg - CNT_W'(1));

  always_comb begin
    dpCtrl          = '0;
    dpCtrl.clearAcc = (state == ST_IDLE) && startReq;
    dpCtrl.loadIn   = inValid && inReady;
    dpCtrl.accEn    = wValid && wReady;
    dpCtrl.latchOut = (state == ST_THRESH);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (startReq) stateNext = ST_LOAD;
      ST_LOAD:   if (inValid) stateNext = (kReg == '0) ? ST_THRESH : ST_ACC;
      ST_ACC:    if (wValid && lastWord) stateNext = ST_THRESH;
      ST_THRESH: stateNext = ST_EMIT;
      ST_EMIT:   if (outReady) stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordCnt <= '0;
      done    <= 1'b0;
    end else begin
      state <= stateNext;
      if (dpCtrl.clearAcc) begin
        wordCnt <= '0;
        done    <= 1'b0;
      end else if (dpCtrl.accEn) begin
        wordCnt <= wordCnt + CNT_W'(1);
      end
      if (outValid && outReady) done <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kReg   <= '0;
      thrReg <= '0;
    end else if (apbWr) begin
      if (regSel == REG_LEN) kReg   <= pwdata[CNT_W-1:0];
      if (regSel == REG_THR) thrReg <= pwdata[ACC_W-1:0];
    end
  end

  always_comb begin
    prdata = '0;
    if (regHit) begin
      unique case (regSel)
        REG_LEN:    prdata = 32'(kReg);
        REG_THR:    prdata = 32'(thrReg);
        REG_STATUS: prdata = {30'b0, done, busy};
        default:    prdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/bnn_datapath.sv
module bnn_datapath
  import bnn_pkg::*;
#(
  parameter int TP    = 32,
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          dpCtrl,
  input  logic [TP-1:0]    inData,
  input  logic [TP-1:0]    wData,
  input  logic [ACC_W-1:0] thr,
  output logic [TP-1:0]    outData
);

  localparam int WORDS  = TP / 32;
  localparam int SLOT_W = $clog2(TP);
  localparam int PC_W   = $clog2(TP) + 1;
  localparam int NODES  = 2 * TP - 1;

  logic [31:0]       inBuf [WORDS];
  logic [TP-1:0]     inVec;
  logic [TP-1:0]     matchVec;
  logic [PC_W-1:0]   node [NODES];
  logic [SLOT_W-1:0] slot;
  logic [ACC_W-1:0]  accArr [TP];
  logic [ACC_W-1:0]  accSel;
  logic [ACC_W:0]    accSum;
  logic [ACC_W-1:0]  accNext;

  // activation buffer, one register per 32-bit word, reassembled by fixed wiring
  for (genvar g = 0; g < WORDS; g++) begin : g_buf
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) inBuf[g] <= '0;
      else if (dpCtrl.loadIn) inBuf[g] <= inData[32*g +: 32];
    end
    assign inVec[32*g +: 32] = inBuf[g];
  end

  assign matchVec = ~(wData ^ inVec);

  // popcount as a balanced binary tree stored in heap order
  for (genvar k = 0; k < TP; k++) begin : g_leaf
    assign node[TP-1+k] = PC_W'(matchVec[k]);
  end
  for (genvar n = 0; n < TP - 1; n++) begin : g_tree
    assign node[n] = node[2*n+1] + node[2*n+2];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) slot <= '0;
    else if (dpCtrl.clearAcc) slot <= '0;
    else if (dpCtrl.accEn) slot <= (slot == SLOT_W'(TP - 1)) ? '0 : slot + SLOT_W'(1);
  end

  // one shared saturating adder, result steered to the selected accumulator
  assign accSel  = accArr[slot];
  assign accSum  = {1'b0, accSel} + (ACC_W + 1)'(node[0]);
  assign accNext = accSum[ACC_W] ? {ACC_W{1'b1}} : accSum[ACC_W-1:0];

  for (genvar a = 0; a < TP; a++) begin : g_acc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) accArr[a] <= '0;
      else if (dpCtrl.clearAcc) accArr[a] <= '0;
      else if (dpCtrl.accEn && (slot == SLOT_W'(a))) accArr[a] <= accNext;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) outData[a] <= 1'b0;
      else if (dpCtrl.latchOut) outData[a] <= (accArr[a] >= thr);
    end
  end

endmodule

// File: rtl/bnn_xnor_accel.sv
module bnn_xnor_accel
  import bnn_pkg::*;
#(
  parameter int TP     = 32,
  parameter int ACC_W  = 16,
  parameter int CNT_W  = 20,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  input  logic              inValid,
  output logic              inReady,
  input  logic [TP-1:0]     inData,
  input  logic              wValid,
  output logic              wReady,
  input  logic [TP-1:0]     wData,
  output logic              outValid,
  input  logic              outReady,
  output logic [TP-1:0]     outData
);

  dpCtrl_t          dpCtrl;
  logic [ACC_W-1:0] thr;

  bnn_ctrl #(
    .ACC_W (ACC_W),
    .CNT_W (CNT_W),
    .ADDR_W(ADDR_W)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .prdata  (prdata),
    .pready  (pready),
    .inValid (inValid),
    .inReady (inReady),
    .wValid  (wValid),
    .wReady  (wReady),
    .outValid(outValid),
    .outReady(outReady),
    .thr     (thr),
    .dpCtrl  (dpCtrl)
  );

  bnn_datapath #(
    .TP   (TP),
    .ACC_W(ACC_W)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .dpCtrl (dpCtrl),
    .inData (inData),
    .wData  (wData),
    .thr    (thr),
    .outData(outData)
  );

endmodule

// File: rtl/bnn_xnor_accel_chk.sv
module bnn_xnor_accel_chk #(
  parameter int TP = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          pready,
  input logic          inValid,
  input logic          inReady,
  input logic          wReady,
  input logic          outValid,
  input logic          outReady,
  input logic [TP-1:0] outData
);

  p_pready_r1: assert property (@(posedge clk) disable iff (!rstN) pready);

  p_single_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> !inReady);

  p_emit_entry_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(!inReady && !wReady));

  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData));

  p_emit_exit_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady |=> !outValid && !inReady && !wReady);

  p_one_phase_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({inReady, wReady, outValid}));

endmodule

bind bnn_xnor_accel bnn_xnor_accel_chk #(.TP(TP)) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .pready  (pready),
  .inValid (inValid),
  .inReady (inReady),
  .wReady  (wReady),
  .outValid(outValid),
  .outReady(outReady),
  .outData (outData)
);

// File: tb/test_bnn_xnor_accel.sv
module test_bnn_xnor_accel;

  localparam int TP     = 32;
  localparam int ACC_W  = 16;
  localparam int CNT_W  = 20;
  localparam int ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              psel = 1'b0;
  logic              penable = 1'b0;
  logic              pwrite = 1'b0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [31:0]       pwdata = '0;
  logic [31:0]       prdata;
  logic              pready;
  logic              inValid = 1'b0;
  logic              inReady;
  logic [TP-1:0]     inData = '0;
  logic              wValid = 1'b0;
  logic              wReady;
  logic [TP-1:0]     wData = '0;
  logic              outValid;
  logic              outReady = 1'b0;
  logic [TP-1:0]     outData;

  int vecCnt  = 0;
  int missCnt = 0;
  int model [TP];

  bnn_xnor_accel #(
    .TP(TP), .ACC_W(ACC_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) i_bnn_xnor_accel (.*);

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vecCnt++;
    if (act !== exp) begin
      missCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apbWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apbRead(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  function automatic logic [TP-1:0] wGen(input int seed, input int j, input logic [TP-1:0] inV);
    logic [31:0] h;
    if (seed < 0) return inV;
    h = 32'(seed) * 32'h9E3779B9 + 32'(j) * 32'h7F4A7C15;
    return inV ^ (h >> (j % 7));
  endfunction

  // one full pass: program, start, load, stream K weights, collect result
  task automatic runPass(input int k, input logic [ACC_W-1:0] thrV, input logic [TP-1:0] inV,
                         input int seed, input bit bubbles, input bit probe, input string req);
    logic [31:0]   st;
    logic [TP-1:0] w;
    logic [TP-1:0] expOut;
    logic [TP-1:0] d0;
    apbWrite(12'h004, 32'(k));
    apbWrite(12'h008, 32'(thrV));
    apbWrite(12'h000, 32'h1);
    for (int i = 0; i < TP; i++) model[i] = 0;
    chk("R2 inReady after start", 64'(inReady), 64'd1);
    apbRead(12'h00C, st);
    chk("R2 status busy after start", 64'(st), 64'd1);
    inData = inV; inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    chk("R4 inReady low after load", 64'(inReady), 64'd0);
    for (int j = 0; j < k; j++) begin
      if (bubbles && (j % 5 == 2)) begin
        wValid = 1'b0;
        @(negedge clk);
      end
      if (probe && (j == k / 2)) begin
        wValid = 1'b0;
        apbWrite(12'h000, 32'h1);
        apbRead(12'h00C, st);
        chk("R3 still busy after start in pass", 64'(st), 64'd1);
      end
      w = wGen(seed, j, inV);
      wData = w; wValid = 1'b1;
      while (!wReady) @(negedge clk);
      if (j == 0) chk("R9 only wReady while streaming", 64'({inReady, outValid}), 64'd0);
      @(posedge clk);
      model[j % TP] = model[j % TP] + $countones(~(w ^ inV));
      if (model[j % TP] > 65535) model[j % TP] = 65535;
      @(negedge clk);
    end
    wValid = 1'b0;
    for (int i = 0; i < TP; i++) expOut[i] = (model[i] >= int'(thrV));
    outReady = 1'b0;
    while (!outValid) @(negedge clk);
    chk("R9 wReady low once done", 64'(wReady), 64'd0);
    d0 = outData;
    chk(req, 64'(d0), 64'(expOut));
    for (int h = 0; h < 2; h++) begin
      @(negedge clk);
      chk("R8 output held under backpressure", 64'({outValid, outData}), 64'({1'b1, d0}));
    end
    outReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    outReady = 1'b0;
    chk("R8 outValid drops after handshake", 64'(outValid), 64'd0);
    apbRead(12'h00C, st);
    chk("R8 status done and idle", 64'(st), 64'd2);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    missCnt++;
    $display("FAIL watchdog expired, run did not complete");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 stream flags after reset", 64'({inReady, wReady, outValid}), 64'd0);
    apbRead(12'h004, rd); chk("R10 K after reset", 64'(rd), 64'd0);
    apbRead(12'h008, rd); chk("R10 threshold after reset", 64'(rd), 64'd0);
    apbRead(12'h00C, rd); chk("R10 status after reset", 64'(rd), 64'd0);

    // R1 register map
    chk("R1 pready", 64'(pready), 64'd1);
    apbWrite(12'h004, 32'h0001_2345); apbRead(12'h004, rd);
    chk("R1 K readback", 64'(rd), 64'h12345);
    apbWrite(12'h004, 32'hFFFF_FFFF); apbRead(12'h004, rd);
    chk("R1 K width", 64'(rd), 64'hFFFFF);
    apbWrite(12'h008, 32'h00AB_CDEF); apbRead(12'h008, rd);
    chk("R1 threshold width", 64'(rd), 64'hCDEF);
    apbRead(12'h000, rd); chk("R1 command reads zero", 64'(rd), 64'd0);
    apbWrite(12'h014, 32'h7); apbRead(12'h004, rd);
    chk("R1 alias write ignored", 64'(rd), 64'hFFFFF);
    apbRead(12'h104, rd); chk("R1 unmapped read zero", 64'(rd), 64'd0);
    apbWrite(12'h006, 32'h3); apbRead(12'h004, rd);
    chk("R1 misaligned write ignored", 64'(rd), 64'hFFFFF);
    apbWrite(12'h000, 32'h2); apbRead(12'h00C, rd);
    chk("R1 command without bit0 no start", 64'(rd), 64'd0);

    // R7 empty pass
    runPass(0, 16'd0, 32'hDEAD_BEEF, 1, 1'b0, 1'b0, "R7 K=0 thr=0 all ones");
    runPass(0, 16'd1, 32'hDEAD_BEEF, 1, 1'b0, 1'b0, "R7 K=0 thr=1 all zeros");

    // R5 accumulation patterns
    runPass(1, 16'd16, 32'h1234_5678, 3, 1'b0, 1'b0, "R5 single word");
    runPass(5, 16'd17, 32'hF0F0_0F0F, 7, 1'b1, 1'b0, "R5 five words with bubbles");
    runPass(32, 16'd16, 32'h0000_0000, 11, 1'b0, 1'b0, "R5 one word per accumulator");
    runPass(33, 16'd20, 32'hFFFF_FFFF, 13, 1'b1, 1'b0, "R5 wrap to slot 0");
    runPass(100, 16'd50, 32'hA5A5_5A5A, 17, 1'b1, 1'b0, "R5 long pass");

    // R3 start ignored mid-pass
    runPass(200, 16'd100, 32'h3C3C_C3C3, 19, 1'b0, 1'b1, "R3 result after ignored start");

    // R7 threshold sweep over every reachable count
    for (int t = 0; t <= 66; t++)
      runPass(64, 16'(t), 32'h9876_5432, 23, 1'b0, 1'b0, "R7 threshold sweep");

    // R6 saturation: 2048 perfect matches per accumulator
    runPass(65536, 16'hFFFF, 32'h5555_AAAA, -1, 1'b0, 1'b0, "R6 saturated accumulators");

    summary();
    $finish;
  end

endmodule